// File: doc/BRIEF.md
# Descriptor Ring Walker

This block is the per-channel front end of a DMA engine. It steps through a circular ring of 8-byte descriptors kept in system memory. Each descriptor holds a 32-bit control word and then a 32-bit buffer pointer. When a poll tick arrives and the channel is switched on, the walker reads the control word at the current ring slot over a single-beat memory port.

If software has handed the slot to hardware (the owner flag is set), the walker reads the buffer pointer. It then issues one transfer request to a data mover, giving the pointer, the byte offset, the byte count and the packet start and end markers. When the mover reports completion, the walker writes the control word back with ownership returned to software and the complete flag set. It then pulses a descriptor-finished event and moves to the next slot. A slot that software still owns is not skipped: the walker parks on it and tries again on the next tick.

Software sets up the ring base, the ring length and the direction while the channel is off. Direction matters in two places. A transmit descriptor carries a five-bit byte offset, while a receive descriptor carries a three-bit one. On receive, the byte count the mover reports replaces the count field in the write-back.

Top module: `dma_ring_walker`

## Requirements
- R1: After reset, mem_req, mem_we, xfer_req and desc_done are 0 and cur_idx is 0.
- R2: A poll while the walker is idle and ch_on is 1 reads the control word at ring_base + 8*cur_idx, and then (if owned) the pointer word at ring_base + 8*cur_idx + 4. Each read completes on the cycle mem_ack is 1.
- R3: A control word with bit 31 (owner) at 0 causes no pointer read, no transfer and no write. cur_idx stays unchanged, and the same slot is read again on the next poll.
- R4: For an owned descriptor, xfer_req rises with xfer_addr = pointer word, xfer_len = control bits 15:0, xfer_sop = bit 29 and xfer_eop = bit 28. xfer_req and these fields hold steady until xfer_done.
- R5: When ch_tx is 1, xfer_off is control bits 27:23. When ch_tx is 0, xfer_off is bits 25:23 with its two upper bits at 0.
- R6: After xfer_done, the walker writes to the control word address. The written word has bit 31 at 0 and bit 30 (complete) at 1, with every other bit kept. On receive (ch_tx 0), bits 15:0 are replaced by the xfer_rx_len captured at xfer_done.
- R7: desc_done is a one-cycle pulse in the cycle after the write is acknowledged, once per finished descriptor. cur_idx shows the next slot from that same cycle.
- R8: cur_idx advances from ring_len-1 to 0.
- R9: While ch_on is 0, polls are ignored. An idle walker with ch_on at 0 returns cur_idx to 0.
- R10: Polls that arrive while a descriptor is in progress are dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_on | input | 1 | Channel enable |
| ch_tx | input | 1 | Direction: 1 transmit, 0 receive |
| ring_base | input | ADDR_W | Byte address of ring slot 0 |
| ring_len | input | LEN_W | Number of ring slots, 1..MAX_DESC |
| poll | input | 1 | Poll tick |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (read data valid) |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | ADDR_W | Buffer pointer |
| xfer_off | output | 5 | Byte offset inside the buffer |
| xfer_len | output | 16 | Byte count |
| xfer_sop | output | 1 | Start of packet marker |
| xfer_eop | output | 1 | End of packet marker |
| xfer_done | input | 1 | Transfer finished |
| xfer_rx_len | input | 16 | Received byte count, sampled with xfer_done |
| desc_done | output | 1 | Descriptor finished pulse |
| cur_idx | output | IDX_W | Current ring slot |

## Verification
The checker relies on a few properties of the environment. mem_ack comes only while mem_req is high and is a single-cycle pulse. xfer_done comes only while xfer_req is high. ring_len stays in the range 1..MAX_DESC and does not change while the channel is on. The bench's memory model answers every request one cycle after it sees it and then drops mem_ack. Its data-mover model raises xfer_done for one cycle after a programmable delay. ring_len and the direction are changed only after ch_on has been low for several idle cycles.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
   localparam int OWN_BIT  = 31;
   localparam int CMPL_BIT = 30;
   localparam int SOP_BIT  = 29;
   localparam int EOP_BIT  = 28;
   localparam int OFF_LSB  = 23;
   localparam int TX_OFF_W = 5;
   localparam int RX_OFF_W = 3;
   localparam int CNT_W    = 16;
   localparam int WORD_W   = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH_CTL,
      ST_FETCH_PTR,
      ST_MOVE,
      ST_RETIRE
   } walk_st_t;
endpackage

// File: rtl/dmaw_ctl_fmt.sv
module dmaw_ctl_fmt
   import dmaw_pkg::*;
#(
   parameter bit RX_LEN_WB = 1'b1
) (
   input  logic [WORD_W-1:0]   ctl_word,
   input  logic                is_tx,
   input  logic [CNT_W-1:0]    rx_count,
   output logic                owned,
   output logic                sop,
   output logic                eop,
   output logic [CNT_W-1:0]    count,
   output logic [TX_OFF_W-1:0] offset,
   output logic [WORD_W-1:0]   wb_word
);
   localparam int PAD_W = TX_OFF_W - RX_OFF_W;

   logic [WORD_W-1:0] handed_back;

   assign owned  = ctl_word[OWN_BIT];
   assign sop    = ctl_word[SOP_BIT];
   assign eop    = ctl_word[EOP_BIT];
   assign count  = ctl_word[CNT_W-1:0];
   assign offset = is_tx ? ctl_word[OFF_LSB +: TX_OFF_W]
                         : {{PAD_W{1'b0}}, ctl_word[OFF_LSB +: RX_OFF_W]};

   always_comb begin
      handed_back           = ctl_word;
      handed_back[OWN_BIT]  = 1'b0;
      handed_back[CMPL_BIT] = 1'b1;
   end

   generate
      if (RX_LEN_WB) begin : g_rx_len
         assign wb_word = is_tx ? handed_back
                                : {handed_back[WORD_W-1:CNT_W], rx_count};
      end else begin : g_keep_len
         logic unused_cnt;
         assign unused_cnt = ^rx_count;
         assign wb_word    = handed_back | {{(WORD_W-1){1'b0}}, unused_cnt & 1'b0};
      end
   endgenerate
endmodule

// File: rtl/dmaw_index.sv
module dmaw_index #(
   parameter int IDX_W = 6,
   parameter int LEN_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [LEN_W-1:0] ring_len,
   output logic [IDX_W-1:0] idx
);
   logic [LEN_W-1:0] idx_plus;
   logic             at_last;

   assign idx_plus = LEN_W'(idx) + LEN_W'(1);
   assign at_last  = (idx_plus == ring_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clr) begin
         idx <= '0;
      end else if (adv) begin
         idx <= at_last ? '0 : idx_plus[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/dma_ring_walker.sv
module dma_ring_walker
   import dmaw_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_DESC  = 64,
   parameter bit RX_LEN_WB = 1'b1,
   localparam int IDX_W    = $clog2(MAX_DESC),
   localparam int LEN_W    = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ch_on,
   input  logic                ch_tx,
   input  logic [ADDR_W-1:0]   ring_base,
   input  logic [LEN_W-1:0]    ring_len,
   input  logic                poll,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [WORD_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic [WORD_W-1:0]   mem_rdata,
   output logic                xfer_req,
   output logic [ADDR_W-1:0]   xfer_addr,
   output logic [TX_OFF_W-1:0] xfer_off,
   output logic [CNT_W-1:0]    xfer_len,
   output logic                xfer_sop,
   output logic                xfer_eop,
   input  logic                xfer_done,
   input  logic [CNT_W-1:0]    xfer_rx_len,
   output logic                desc_done,
   output logic [IDX_W-1:0]    cur_idx
);
   localparam int SLOT_SH = 3;
   localparam int PTR_OFS = 4;

   generate
      if (MAX_DESC < 2 || (MAX_DESC & (MAX_DESC - 1)) != 0) begin : g_bad_depth
         $error("MAX_DESC must be a power of two of at least 2");
      end
      if (ADDR_W < IDX_W + SLOT_SH + 1 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("ADDR_W must cover the ring and fit a descriptor word");
      end
   endgenerate

   walk_st_t            state;
   logic [WORD_W-1:0]   ctl_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [CNT_W-1:0]    rxcnt_q;
   logic                done_q;
   logic                owned;
   logic                idx_clr;
   logic                idx_adv;
   logic [ADDR_W-1:0]   slot_addr;

   dmaw_ctl_fmt #(.RX_LEN_WB(RX_LEN_WB)) u_fmt (
      .ctl_word (ctl_q),
      .is_tx    (ch_tx),
      .rx_count (rxcnt_q),
      .owned    (owned),
      .sop      (xfer_sop),
      .eop      (xfer_eop),
      .count    (xfer_len),
      .offset   (xfer_off),
      .wb_word  (mem_wdata)
   );

   dmaw_index #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (idx_clr),
      .adv      (idx_adv),
      .ring_len (ring_len),
      .idx      (cur_idx)
   );

   assign idx_clr   = (state == ST_IDLE) && !ch_on;
   assign idx_adv   = (state == ST_RETIRE) && mem_ack;
   assign slot_addr = ring_base + (ADDR_W'(cur_idx) << SLOT_SH);

   assign mem_req   = (state == ST_FETCH_CTL) || (state == ST_FETCH_PTR) ||
                      (state == ST_RETIRE);
   assign mem_we    = (state == ST_RETIRE);
   assign mem_addr  = (state == ST_FETCH_PTR) ? slot_addr + ADDR_W'(PTR_OFS)
                                              : slot_addr;
   assign xfer_req  = (state == ST_MOVE);
   assign xfer_addr = ptr_q;
   assign desc_done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ctl_q   <= '0;
         ptr_q   <= '0;
         rxcnt_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (ch_on && poll) state <= ST_FETCH_CTL;
            end
            ST_FETCH_CTL: begin
               if (mem_ack) begin
                  ctl_q <= mem_rdata;
                  state <= mem_rdata[OWN_BIT] ? ST_FETCH_PTR : ST_IDLE;
               end
            end
            ST_FETCH_PTR: begin
               if (mem_ack) begin
                  ptr_q <= mem_rdata[ADDR_W-1:0];
                  state <= ST_MOVE;
               end
            end
            ST_MOVE: begin
               if (xfer_done) begin
                  rxcnt_q <= xfer_rx_len;
                  state   <= ST_RETIRE;
               end
            end
            ST_RETIRE: begin
               if (mem_ack) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = owned & ^mem_rdata[WORD_W-1:ADDR_W] & 1'b0;
endmodule

// File: rtl/dmaw_chk.sv
module dmaw_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int LEN_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ch_on,
   input logic [LEN_W-1:0]  ring_len,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [31:0]       mem_wdata,
   input logic              xfer_req,
   input logic              xfer_done,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [15:0]       xfer_len,
   input logic              desc_done,
   input logic [IDX_W-1:0]  cur_idx
);
   // R4
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

   // R6
   wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (!mem_wdata[31] && mem_wdata[30]));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |=> !desc_done);

   // R7
   done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_done) |-> $past(mem_req && mem_we && mem_ack));

   // R8
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_on && ring_len != '0) |-> (LEN_W'(cur_idx) < ring_len));

   // R10
   one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && xfer_req));
endmodule

bind dma_ring_walker dmaw_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ch_on     (ch_on),
   .ring_len  (ring_len),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_wdata (mem_wdata),
   .xfer_req  (xfer_req),
   .xfer_done (xfer_done),
   .xfer_addr (xfer_addr),
   .xfer_len  (xfer_len),
   .desc_done (desc_done),
   .cur_idx   (cur_idx)
);

// File: tb/sim_dma_ring_walker.sv
`timescale 1ns/1ps
module sim_dma_ring_walker;
   localparam int ADDR_W = 32;
   localparam int IDX_W  = 6;
   localparam int LEN_W  = 7;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam logic [31:0] OWN  = 32'h8000_0000;
   localparam logic [31:0] CMPL = 32'h4000_0000;
   localparam logic [31:0] SOP  = 32'h2000_0000;
   localparam logic [31:0] EOP  = 32'h1000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ch_on = 1'b0, ch_tx = 1'b1, poll = 1'b0;
   logic [LEN_W-1:0] ring_len = 7'd64;
   logic mem_req, mem_we, mem_ack, xfer_req, xfer_sop, xfer_eop, xfer_done, desc_done;
   logic [ADDR_W-1:0] mem_addr, xfer_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic [4:0]  xfer_off;
   logic [15:0] xfer_len, xfer_rx_len;
   logic [IDX_W-1:0] cur_idx;

   always #2.5 clk = ~clk;

   dma_ring_walker u0 (
      .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .ch_tx(ch_tx),
      .ring_base(BASE), .ring_len(ring_len), .poll(poll),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_off(xfer_off),
      .xfer_len(xfer_len), .xfer_sop(xfer_sop), .xfer_eop(xfer_eop),
      .xfer_done(xfer_done), .xfer_rx_len(xfer_rx_len),
      .desc_done(desc_done), .cur_idx(cur_idx)
   );

   // memory model: one-cycle answer, single-cycle ack
   logic [31:0] mem [0:127];
   logic [6:0]  widx;
   int n_rd = 0, n_wr = 0, n_xfer = 0, n_done = 0;
   logic [31:0] last_rd_addr;
   assign widx = 7'((mem_addr - BASE) >> 2);
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && !mem_ack) begin
            mem_rdata <= mem[widx];
            if (mem_we) begin
               mem[widx] <= mem_wdata;
               n_wr <= n_wr + 1;
            end else begin
               n_rd <= n_rd + 1;
               last_rd_addr <= mem_addr;
            end
         end
         if (desc_done) n_done <= n_done + 1;
      end
   end

   // data mover model
   int xdelay = 3;
   int xcnt = 0;
   logic [15:0] rx_ret = 16'h0;
   logic [31:0] cap_addr;
   logic [4:0]  cap_off;
   logic [15:0] cap_len;
   logic        cap_sop, cap_eop;
   assign xfer_rx_len = rx_ret;
   always @(posedge clk) begin
      if (!rst_n) begin
         xfer_done <= 1'b0;
         xcnt <= 0;
      end else if (xfer_req && !xfer_done) begin
         if (xcnt >= xdelay) begin
            xfer_done <= 1'b1;
            xcnt <= 0;
            n_xfer <= n_xfer + 1;
            cap_addr <= xfer_addr; cap_off <= xfer_off; cap_len <= xfer_len;
            cap_sop <= xfer_sop; cap_eop <= xfer_eop;
         end else begin
            xcnt <= xcnt + 1;
         end
      end else begin
         xfer_done <= 1'b0;
      end
   end

   int checks = 0, errors = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_poll();
      @(negedge clk); poll = 1'b1;
      @(negedge clk); poll = 1'b0;
   endtask

   task automatic chan_off();
      @(negedge clk); ch_on = 1'b0;
      cycles(4);
   endtask

   task automatic t_reset();
      chk("R1 mem_req", 32'(mem_req), 0);
      chk("R1 mem_we", 32'(mem_we), 0);
      chk("R1 xfer_req", 32'(xfer_req), 0);
      chk("R1 desc_done", 32'(desc_done), 0);
      chk("R1 cur_idx", 32'(cur_idx), 0);
   endtask

   task automatic t_not_owned();
      int rd0, wr0, xf0;
      mem[0] = 32'h0000_0040; mem[1] = 32'hDEAD_0000;
      ch_tx = 1'b1; ch_on = 1'b1;
      rd0 = n_rd; wr0 = n_wr; xf0 = n_xfer;
      do_poll(); cycles(12);
      chk("R3 one read", 32'(n_rd - rd0), 1);
      chk("R2 ctl addr", last_rd_addr, BASE);
      chk("R3 no xfer", 32'(n_xfer - xf0), 0);
      chk("R3 no write", 32'(n_wr - wr0), 0);
      chk("R3 idx kept", 32'(cur_idx), 0);
      do_poll(); cycles(12);
      chk("R3 retry same slot", last_rd_addr, BASE);
   endtask

   task automatic t_tx_one();
      logic [31:0] c;
      c = OWN | SOP | EOP | (32'h15 << 23) | 32'h0123;
      mem[0] = c; mem[1] = 32'hA000_0040;
      do_poll(); cycles(20);
      chk("R2 ptr addr", last_rd_addr, BASE + 4);
      chk("R4 addr", cap_addr, 32'hA000_0040);
      chk("R4 len", 32'(cap_len), 32'h0123);
      chk("R4 sop", 32'(cap_sop), 1);
      chk("R4 eop", 32'(cap_eop), 1);
      chk("R5 tx off", 32'(cap_off), 32'h15);
      chk("R6 tx writeback", mem[0], (c & ~OWN) | CMPL);
      chk("R7 idx advance", 32'(cur_idx), 1);
   endtask

   task automatic t_rx_one();
      logic [31:0] c;
      chan_off();
      chk("R9 idx cleared", 32'(cur_idx), 0);
      ch_tx = 1'b0; rx_ret = 16'h0456;
      c = OWN | SOP | (32'h1D << 23) | 32'h0100;
      mem[0] = c; mem[1] = 32'hB000_0000;
      @(negedge clk); ch_on = 1'b1;
      do_poll(); cycles(20);
      chk("R5 rx off", 32'(cap_off), 32'h5);
      chk("R4 rx eop", 32'(cap_eop), 0);
      chk("R6 rx writeback", mem[0], (((c & ~OWN) | CMPL) & 32'hFFFF_0000) | 32'h0456);
   endtask

   task automatic t_wrap();
      int d0;
      bit seen;
      chan_off();
      ring_len = 7'd3; ch_tx = 1'b1;
      for (int i = 0; i < 3; i++) begin
         mem[2*i] = OWN | EOP | 32'(i + 1);
         mem[2*i+1] = 32'hC000_0000 + 32'(i);
      end
      @(negedge clk); ch_on = 1'b1;
      d0 = n_done;
      for (int i = 0; i < 3; i++) begin
         do_poll();
         seen = 0;
         for (int k = 0; k < 30 && !seen; k++) begin
            @(negedge clk);
            if (desc_done) begin
               seen = 1;
               chk("R7 idx with pulse", 32'(cur_idx), (i == 2) ? 0 : 32'(i + 1));
               @(negedge clk);
               chk("R7 pulse one cycle", 32'(desc_done), 0);
            end
         end
         chk("R7 pulse seen", 32'(seen), 1);
      end
      chk("R7 one pulse each", 32'(n_done - d0), 3);
      chk("R8 wrapped to 0", 32'(cur_idx), 0);
   endtask

   task automatic t_off_ignored();
      int rd0;
      chan_off();
      rd0 = n_rd;
      do_poll(); cycles(10);
      chk("R9 poll ignored", 32'(n_rd - rd0), 0);
      chk("R9 no request", 32'(mem_req), 0);
   endtask

   task automatic t_busy_poll();
      int rd0, x0;
      ring_len = 7'd64; xdelay = 20;
      mem[0] = OWN | SOP | 32'h0010; mem[1] = 32'hD000_0000;
      mem[2] = OWN | EOP | 32'h0020; mem[3] = 32'hD000_1000;
      @(negedge clk); ch_on = 1'b1;
      rd0 = n_rd; x0 = n_xfer;
      do_poll(); cycles(6);
      for (int i = 0; i < 5; i++) do_poll();
      cycles(40);
      chk("R10 one xfer", 32'(n_xfer - x0), 1);
      chk("R10 two reads", 32'(n_rd - rd0), 2);
      chk("R10 idx once", 32'(cur_idx), 1);
      chk("R10 next slot untouched", mem[2], OWN | EOP | 32'h0020);
   endtask

   initial begin
      cycles(3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      cycles(2);
      t_not_owned();
      t_tx_one();
      t_rx_one();
      t_wrap();
      t_off_ignored();
      t_busy_poll();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule